// File: doc/BRIEF.md
# Reloadable Interval Timer Channel

This block is one down-counting divider channel of a programmable interval timer. A slow input clock reaches it as a single-cycle enable in the system clock domain. Each qualified tick lowers a 16-bit current count. When the count runs out, the channel reloads from its reload register and drives its active-low output low for one system cycle. The result is a periodic rate output whose period, in ticks, equals the reload value.

Software-facing logic sits in a separate register-interface block, which drives this channel. That block selects how reload bytes are written (low only, high only, or a low/high pair), chooses binary or BCD counting, and sends data bytes. It reads back the current count and a pending-reload flag. A gate input lets ticks reach the counter, and a rising edge of the gate restarts the count from the reload register. A newly written reload value does not disturb a running count. It waits for the next reload event, and the pending flag shows whether it is still waiting.

Top module: `interval_timer_channel`

## Requirements
- R1: After reset the current count is 0x0000, the pending flag is 1 and the output is high.
- R2: A tick with the gate high and the count above 1 lowers the count by one, and the output stays high.
- R3: A tick with the gate high and the count at 1 copies the reload register into the count, and the output is low for exactly the next system cycle. A reload value N therefore gives one output pulse every N ticks.
- R4: A count of zero stands for the full range: one tick takes 0x0000 to 0xFFFF in binary mode and to 0x9999 in BCD mode. A reload value of 0 thus divides by 65536 or by 10000.
- R5: With the BCD select set at configuration, each 4-bit nibble is one decimal digit and decrements with decimal borrow (0x0010 becomes 0x0009, 0x1000 becomes 0x0999).
- R6: While the gate is low, ticks leave the count unchanged and the output stays high.
- R7: A rising edge of the gate loads the reload register into the count at the next system clock edge. This takes priority over a tick in the same cycle.
- R8: Writing a reload value leaves the running count unchanged. The new value enters the count only at the next reload event of R3 or R7.
- R9: The pending flag is set by a configuration write and by a completed reload write. It is cleared when the reload register is copied into the count.
- R10: The write format field is coded 01 for low byte only (high byte becomes 0), 10 for high byte only (low byte becomes 0), and 11 or 00 for a low/high pair. In the pair format the reload register changes only when the high byte arrives.
- R11: A configuration write resets the pair format so that the next data byte is taken as a low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Single-cycle enable, one per input clock tick |
| gateIn | input | 1 | Gate: high lets ticks count; a rising edge reloads |
| cfgWr | input | 1 | Configuration write strobe |
| cfgAccess | input | 2 | Byte write format applied on cfgWr |
| cfgBcd | input | 1 | BCD counting select applied on cfgWr |
| dataWr | input | 1 | Reload data byte strobe |
| dataIn | input | 8 | Reload data byte |
| curCount | output | 16 | Current count |
| nullCount | output | 1 | Pending flag: a written reload value is not yet in the count |
| timerOut | output | 1 | Rate output, low for one cycle after each expiry |

## Verification
The bench targets the borrow cases of the BCD decrement and the wrap of a zero count to the full range. A design with a plain binary decrement would show 0x000F or 0xFFFF where 0x0009 or 0x9999 belongs. It writes a new reload value in the middle of a period and checks that the running count carries on and that the value first appears at the next expiry. A design that loaded writes at once would break the period early. It also checks an orphaned low byte followed by a reconfiguration, and a gate rising edge that lands on the same tick. A design with a stale byte toggle would assemble 0x2209 instead of 0x0022, and one that gave the tick priority would decrement rather than reload.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

  // Byte write format for the reload register
  typedef enum logic [1:0] {
    ACC_PAIR_ALT = 2'b00,
    ACC_LOW      = 2'b01,
    ACC_HIGH     = 2'b10,
    ACC_PAIR     = 2'b11
  } accMode_t;

  // Strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic loadCount;   // copy reload register into count
    logic decCount;    // decrement count by one
    logic wrLowOnly;   // reload <= {0, byte}
    logic wrHighOnly;  // reload <= {byte, 0}
    logic stashLow;    // hold low byte of a pair
    logic commitPair;  // reload <= {byte, held low}
  } ctrlStrb_t;

endpackage

// File: rtl/itimer_datapath.sv
module itimer_datapath
  import itimer_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W,
  localparam int NIB   = CNT_W / 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              bcdMode,
  input  logic [BYTE_W-1:0] dataIn,
  output logic [CNT_W-1:0]  curCount,
  output logic              atOne
);

  logic [CNT_W-1:0]  reloadReg;
  logic [BYTE_W-1:0] lowHold;
  logic [CNT_W-1:0]  countReg;
  logic [CNT_W-1:0]  binNext;
  logic [CNT_W-1:0]  bcdNext;

  // Binary decrement wraps 0 to all ones (full range)
  assign binNext = countReg - CNT_W'(1);

  // Decimal decrement: borrow ripples through zero digits, 0 wraps to 9
  always_comb begin
    logic brw;
    brw     = 1'b1;
    bcdNext = countReg;
    for (int i = 0; i < NIB; i++) begin
      if (brw) begin
        if (countReg[4*i +: 4] == 4'd0) begin
          bcdNext[4*i +: 4] = 4'd9;
        end else begin
          bcdNext[4*i +: 4] = countReg[4*i +: 4] - 4'd1;
          brw = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadReg <= '0;
      lowHold   <= '0;
    end else begin
      if (strb.wrLowOnly)  reloadReg <= {{BYTE_W{1'b0}}, dataIn};
      if (strb.wrHighOnly) reloadReg <= {dataIn, {BYTE_W{1'b0}}};
      if (strb.commitPair) reloadReg <= {dataIn, lowHold};
      if (strb.stashLow)   lowHold   <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg <= '0;
    end else if (strb.loadCount) begin
      countReg <= reloadReg;
    end else if (strb.decCount) begin
      countReg <= bcdMode ? bcdNext : binNext;
    end
  end

  assign atOne    = (countReg == CNT_W'(1));
  assign curCount = countReg;

endmodule

// File: rtl/itimer_ctrl.sv
module itimer_ctrl
  import itimer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       gateIn,
  input  logic       cfgWr,
  input  logic [1:0] cfgAccess,
  input  logic       cfgBcd,
  input  logic       dataWr,
  input  logic       atOne,
  output ctrlStrb_t  strb,
  output logic       bcdMode,
  output logic       nullCount,
  output logic       timerOut
);

  accMode_t accMode;
  logic     secondByte;
  logic     gatePrev;
  logic     nullReg;
  logic     outReg;
  logic     gateRise;
  logic     termHit;
  logic     dataAct;
  logic     pairMode;
  logic     commitAny;

  assign gateRise  = gateIn & ~gatePrev;
  assign termHit   = tickEn & gateIn & atOne & ~gateRise;
  assign dataAct   = dataWr & ~cfgWr;
  assign pairMode  = (accMode == ACC_PAIR) || (accMode == ACC_PAIR_ALT);

  always_comb begin
    strb            = '0;
    strb.loadCount  = gateRise | termHit;
    strb.decCount   = tickEn & gateIn & ~atOne & ~gateRise;
    strb.wrLowOnly  = dataAct & (accMode == ACC_LOW);
    strb.wrHighOnly = dataAct & (accMode == ACC_HIGH);
    strb.stashLow   = dataAct & pairMode & ~secondByte;
    strb.commitPair = dataAct & pairMode & secondByte;
  end

  assign commitAny = strb.wrLowOnly | strb.wrHighOnly | strb.commitPair;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accMode    <= ACC_PAIR;
      bcdMode    <= 1'b0;
      secondByte <= 1'b0;
      gatePrev   <= 1'b0;
      nullReg    <= 1'b1;
      outReg     <= 1'b1;
    end else begin
      gatePrev <= gateIn;
      outReg   <= ~termHit;
      if (cfgWr) begin
        accMode    <= accMode_t'(cfgAccess);
        bcdMode    <= cfgBcd;
        secondByte <= 1'b0;
      end else if (strb.stashLow) begin
        secondByte <= 1'b1;
      end else if (strb.commitPair) begin
        secondByte <= 1'b0;
      end
      if (cfgWr || commitAny) begin
        nullReg <= 1'b1;
      end else if (strb.loadCount) begin
        nullReg <= 1'b0;
      end
    end
  end

  assign nullCount = nullReg;
  assign timerOut  = outReg;

endmodule

// File: rtl/interval_timer_channel.sv
module interval_timer_channel
  import itimer_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              gateIn,
  input  logic              cfgWr,
  input  logic [1:0]        cfgAccess,
  input  logic              cfgBcd,
  input  logic              dataWr,
  input  logic [BYTE_W-1:0] dataIn,
  output logic [CNT_W-1:0]  curCount,
  output logic              nullCount,
  output logic              timerOut
);

  ctrlStrb_t strb;
  logic      bcdMode;
  logic      atOne;

  itimer_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .gateIn    (gateIn),
    .cfgWr     (cfgWr),
    .cfgAccess (cfgAccess),
    .cfgBcd    (cfgBcd),
    .dataWr    (dataWr),
    .atOne     (atOne),
    .strb      (strb),
    .bcdMode   (bcdMode),
    .nullCount (nullCount),
    .timerOut  (timerOut)
  );

  itimer_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .bcdMode  (bcdMode),
    .dataIn   (dataIn),
    .curCount (curCount),
    .atOne    (atOne)
  );

endmodule

// File: rtl/itimer_checker.sv
module itimer_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             gateIn,
  input logic [CNT_W-1:0] curCount,
  input logic             nullCount,
  input logic             timerOut
);

  // Own copy of the previous gate level, reset with the design
  logic gateSeen;
  always_ff @(posedge clk) begin
    if (!rstN) gateSeen <= 1'b0;
    else       gateSeen <= gateIn;
  end

  // R2: steady gate, tick, low digit 2..9 -> count drops by one
  p_tick_decrements_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && gateIn && gateSeen && curCount[3:0] >= 4'd2 && curCount[3:0] <= 4'd9)
      |=> (curCount == $past(curCount) - CNT_W'(1)));

  // R3: output falls only after the count stood at one
  p_pulse_at_expiry_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timerOut) |-> ($past(curCount) == CNT_W'(1)));

  // R6: gate low freezes the count
  p_gate_low_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    !gateIn |=> $stable(curCount));

  // R6: gate low keeps output high
  p_gate_low_out_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    !gateIn |=> timerOut);

  // R9: pending flag clears only through a reload, which needs the gate high
  p_null_clear_needs_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nullCount) |-> $past(gateIn));

endmodule

bind interval_timer_channel itimer_checker u_itimer_checker (.*);

// File: tb/interval_timer_channel_bench.sv
module interval_timer_channel_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        gateIn = 1'b0;
  logic        cfgWr = 1'b0;
  logic [1:0]  cfgAccess = 2'b11;
  logic        cfgBcd = 1'b0;
  logic        dataWr = 1'b0;
  logic [7:0]  dataIn = 8'h00;
  logic [15:0] curCount;
  logic        nullCount;
  logic        timerOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  interval_timer_channel u_interval_timer_channel (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .gateIn(gateIn),
    .cfgWr(cfgWr), .cfgAccess(cfgAccess), .cfgBcd(cfgBcd),
    .dataWr(dataWr), .dataIn(dataIn),
    .curCount(curCount), .nullCount(nullCount), .timerOut(timerOut)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge; outputs are sampled there
  task automatic tick();
    @(negedge clk) tickEn = 1'b1;
    @(negedge clk) tickEn = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] acc, input logic bcd);
    @(negedge clk) begin cfgWr = 1'b1; cfgAccess = acc; cfgBcd = bcd; end
    @(negedge clk) cfgWr = 1'b0;
  endtask

  task automatic wrByte(input logic [7:0] b);
    @(negedge clk) begin dataWr = 1'b1; dataIn = b; end
    @(negedge clk) dataWr = 1'b0;
  endtask

  task automatic setGate(input logic g);
    @(negedge clk) gateIn = g;
    @(negedge clk);
  endtask

  task automatic regate();
    setGate(1'b0);
    setGate(1'b1);
  endtask

  task automatic t_reset();
    chk("R1 count", curCount, 16'h0000);
    chk("R1 pending", {15'd0, nullCount}, 16'd1);
    chk("R1 out", {15'd0, timerOut}, 16'd1);
  endtask

  task automatic t_period();
    cfg(2'b11, 1'b0);
    wrByte(8'h05); wrByte(8'h00);
    chk("R9 set by write", {15'd0, nullCount}, 16'd1);
    setGate(1'b1);
    chk("R7 gate rise load", curCount, 16'h0005);
    chk("R9 cleared by load", {15'd0, nullCount}, 16'd0);
    for (int k = 4; k >= 1; k--) begin
      tick();
      chk("R2 decrement", curCount, 16'(k));
      chk("R2 out high", {15'd0, timerOut}, 16'd1);
    end
    tick();
    chk("R3 reload", curCount, 16'h0005);
    chk("R3 out low", {15'd0, timerOut}, 16'd0);
    idle();
    chk("R3 out back high", {15'd0, timerOut}, 16'd1);
  endtask

  task automatic t_deferred();
    tick();
    wrByte(8'h03); wrByte(8'h00);
    chk("R8 count kept", curCount, 16'h0004);
    chk("R9 pending after write", {15'd0, nullCount}, 16'd1);
    for (int k = 3; k >= 1; k--) begin
      tick();
      chk("R8 old period runs", curCount, 16'(k));
    end
    tick();
    chk("R8 new value at expiry", curCount, 16'h0003);
    chk("R9 cleared at expiry", {15'd0, nullCount}, 16'd0);
  endtask

  task automatic t_gate();
    tick();
    chk("R2 count", curCount, 16'h0002);
    setGate(1'b0);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R6 count frozen", curCount, 16'h0002);
      chk("R6 out high", {15'd0, timerOut}, 16'd1);
    end
    // rise together with a tick: reload wins
    @(negedge clk) begin gateIn = 1'b1; tickEn = 1'b1; end
    @(negedge clk) tickEn = 1'b0;
    chk("R7 rise beats tick", curCount, 16'h0003);
  endtask

  task automatic t_pairs();
    cfg(2'b11, 1'b0);
    chk("R9 set by config", {15'd0, nullCount}, 16'd1);
    wrByte(8'h07);
    regate();
    chk("R10 half pair not committed", curCount, 16'h0003);
    wrByte(8'h00);
    regate();
    chk("R10 pair committed", curCount, 16'h0007);
    wrByte(8'h09);
    cfg(2'b11, 1'b0);
    wrByte(8'h22); wrByte(8'h00);
    regate();
    chk("R11 toggle reset by config", curCount, 16'h0022);
  endtask

  task automatic t_single();
    cfg(2'b01, 1'b0);
    wrByte(8'h34);
    regate();
    chk("R10 low only", curCount, 16'h0034);
    cfg(2'b10, 1'b0);
    wrByte(8'h12);
    regate();
    chk("R10 high only", curCount, 16'h1200);
    cfg(2'b00, 1'b0);
    wrByte(8'h45); wrByte(8'h01);
    regate();
    chk("R10 code 00 pair", curCount, 16'h0145);
  endtask

  task automatic t_zero();
    cfg(2'b11, 1'b0);
    wrByte(8'h00); wrByte(8'h00);
    regate();
    chk("R4 zero loaded", curCount, 16'h0000);
    tick();
    chk("R4 binary wrap", curCount, 16'hFFFF);
    chk("R4 no pulse at zero", {15'd0, timerOut}, 16'd1);
    cfg(2'b11, 1'b1);
    wrByte(8'h00); wrByte(8'h00);
    regate();
    tick();
    chk("R4 BCD wrap", curCount, 16'h9999);
  endtask

  task automatic t_bcd();
    cfg(2'b11, 1'b1);
    wrByte(8'h10); wrByte(8'h00);
    regate();
    tick();
    chk("R5 digit borrow", curCount, 16'h0009);
    wrByte(8'h00); wrByte(8'h10);
    regate();
    tick();
    chk("R5 ripple borrow", curCount, 16'h0999);
    wrByte(8'h02); wrByte(8'h00);
    regate();
    tick();
    chk("R5 BCD count", curCount, 16'h0001);
    tick();
    chk("R3 BCD expiry reload", curCount, 16'h0002);
    chk("R3 BCD out low", {15'd0, timerOut}, 16'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();
    t_reset();
    t_period();
    t_deferred();
    t_gate();
    t_pairs();
    t_single();
    t_zero();
    t_bcd();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule